// File: doc/BRIEF.md
# Multiphase Token Ring Sequencer

This block sets the switching order of a multiphase converter built from one controller and a chain of phase stages. All stages share one system clock. The controller injects a single token. Each stage captures the token in one flip-flop on the shared clock and hands it to the next stage. The last stage's output leaves the block on `ring_out`, and the board-level wiring brings it back on `ring_in`. A stage starts its switching cycle in the clock cycle in which it holds the token. Neighbouring phases are therefore one system clock apart, and the system clock runs at the phase count times the per-phase switching rate.

After reset the controller sends one discovery token and counts clock edges until the token returns. The count becomes the phase count. If the token never returns within a configurable limit, or the return line is already high before any token could arrive, the loop is declared broken. Once the count is known, the controller issues one token every `phase_count` cycles, and each stage receives its start pulse. A stage can be isolated for debug. It then gives no start pulses but still forwards the token with unchanged timing. When the chain is built with a single stage, that stage takes its timing straight from the system clock.

Top module: `phase_chain_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is forced to zero on that edge: `pwm_start`, `ring_out`, `phase_count`, `count_valid` and `loop_fault`.
- R2: Edges are numbered from edge 0, the first rising edge with `rst_n` high. At edge 0 the controller injects exactly one discovery token. Stage k (0-based) holds it after edge k+1, so `ring_out` is high only after edge N_PHASES. No further token is injected before `count_valid` rises.
- R3: Let L (1 ≤ L ≤ MAX_WAIT) be the edge number after which `ring_in` is first high. At edge L+1 the controller latches `phase_count` = L and raises `count_valid`. Both then stay unchanged until reset.
- R4: If `ring_in` stays low through edge MAX_WAIT+1, `loop_fault` rises after edge MAX_WAIT+1. It stays high until reset, and `count_valid` stays low.
- R5: If `ring_in` is already high when edge 1 samples it (a return after zero edges), `loop_fault` rises after edge 1.
- R6: While `count_valid` is high, the controller injects one token every `phase_count` cycles. The first injection is at edge L+1. `pwm_start[i]` is high for exactly the cycles in which stage i holds a token.
- R7: `pwm_start` stays all-zero while discovery is running and after a loop fault.
- R8: A stage whose `phase_iso` bit is 1 never raises its `pwm_start` bit. It still forwards the token, so `ring_out` and all later stages keep their timing.
- R9: When `phase_count` is at least N_PHASES, at most one `pwm_start` bit is high in any cycle.
- R10: With N_PHASES = 1, the stage's timing comes from the system clock. `pwm_start[0]` is high on every cycle while `count_valid` is high and the stage is not isolated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_iso | input | N_PHASES | Per-stage debug isolation; bit i silences stage i's start pulse |
| ring_in | input | 1 | Token returning to the controller from the end of the chain |
| ring_out | output | 1 | Token leaving the last stage |
| pwm_start | output | N_PHASES | Per-stage switching-cycle start strobe |
| phase_count | output | $clog2(MAX_WAIT+1) | Measured number of phases |
| count_valid | output | 1 | Discovery done; `phase_count` is valid and tokens are circulating |
| loop_fault | output | 1 | Token return missing or premature |

## Verification
Some properties are checked by assertions on every cycle. The assertions check the edge at which discovery finishes or fails against the cycles elapsed since reset. They also check that the result and the fault flag stay fixed, that the controller's injection spacing equals the latched count, that isolated or idle stages stay silent, and that no two start strobes coincide. Other behaviour is shown only by the bench scenarios. These cover the exact cycle of each stage's strobe for a given return delay, and the boundary between a count of MAX_WAIT and a timeout. They also cover the stuck-high return line, unchanged downstream timing behind an isolated stage, and the clock-timed single-stage variant.

// File: rtl/phase_chain_pkg.sv
package phase_chain_pkg;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_SEEK,
    CS_RUN,
    CS_FAULT
  } ctrl_state_e;

  typedef enum logic [1:0] {
    SEEK_WAIT,
    SEEK_FOUND,
    SEEK_FAIL
  } seek_res_e;

  // Outcome of one discovery edge: ret is the sampled return line and
  // cnt the number of edges already spent waiting.
  function automatic seek_res_e seek_step(input logic ret, input int cnt,
                                          input int max_wait);
    if (ret) return (cnt == 0) ? SEEK_FAIL : SEEK_FOUND;
    if (cnt >= max_wait) return SEEK_FAIL;
    return SEEK_WAIT;
  endfunction

  // True on the last slot of an injection period.
  function automatic logic period_wrap(input int pos, input int period);
    return (pos + 1) >= period;
  endfunction

endpackage

// File: rtl/phase_chain_ctrl.sv
module phase_chain_ctrl
  import phase_chain_pkg::*;
#(
  parameter int MAX_WAIT = 16,
  parameter int CNT_W    = $clog2(MAX_WAIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_in,
  output logic             ctrl_tok,
  output logic [CNT_W-1:0] phase_count,
  output logic             count_valid,
  output logic             loop_fault
);

  ctrl_state_e      state;
  logic [CNT_W-1:0] wait_cnt;
  logic [CNT_W-1:0] slot_pos;
  seek_res_e        seek_res;
  logic             slot_wrap;

  assign seek_res  = seek_step(ring_in, int'(wait_cnt), MAX_WAIT);
  assign slot_wrap = period_wrap(int'(slot_pos), int'(phase_count));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= CS_IDLE;
      wait_cnt    <= '0;
      slot_pos    <= '0;
      phase_count <= '0;
      ctrl_tok    <= 1'b0;
    end else begin
      unique case (state)
        CS_IDLE: begin
          ctrl_tok <= 1'b1;
          wait_cnt <= '0;
          state    <= CS_SEEK;
        end
        CS_SEEK: begin
          ctrl_tok <= 1'b0;
          unique case (seek_res)
            SEEK_FOUND: begin
              phase_count <= wait_cnt;
              slot_pos    <= '0;
              ctrl_tok    <= 1'b1;
              state       <= CS_RUN;
            end
            SEEK_FAIL: state <= CS_FAULT;
            default:   wait_cnt <= wait_cnt + 1'b1;
          endcase
        end
        CS_RUN: begin
          if (slot_wrap) begin
            slot_pos <= '0;
            ctrl_tok <= 1'b1;
          end else begin
            slot_pos <= slot_pos + 1'b1;
            ctrl_tok <= 1'b0;
          end
        end
        default: ctrl_tok <= 1'b0;
      endcase
    end
  end

  assign count_valid = (state == CS_RUN);
  assign loop_fault  = (state == CS_FAULT);

endmodule

// File: rtl/phase_chain_stage.sv
module phase_chain_stage #(
  parameter bit CLOCK_TIMED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tok_in,
  input  logic run,
  input  logic iso,
  output logic tok_out,
  output logic pwm_start
);

  logic timing;

  always_ff @(posedge clk) begin
    if (!rst_n) tok_out <= 1'b0;
    else        tok_out <= tok_in;
  end

  generate
    if (CLOCK_TIMED) begin : g_clock_timed
      assign timing = 1'b1;
    end else begin : g_token_timed
      assign timing = tok_out;
    end
  endgenerate

  assign pwm_start = timing & run & ~iso;

endmodule

// File: rtl/phase_chain_seq.sv
module phase_chain_seq #(
  parameter int N_PHASES = 4,
  parameter int MAX_WAIT = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_PHASES-1:0]           phase_iso,
  input  logic                          ring_in,
  output logic                          ring_out,
  output logic [N_PHASES-1:0]           pwm_start,
  output logic [$clog2(MAX_WAIT+1)-1:0] phase_count,
  output logic                          count_valid,
  output logic                          loop_fault
);

  localparam int CNT_W = $clog2(MAX_WAIT + 1);
  localparam bit SINGLE = (N_PHASES == 1);

  logic              ctrl_tok;
  logic [N_PHASES:0] tok_chain;

  phase_chain_ctrl #(
    .MAX_WAIT(MAX_WAIT),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_in    (ring_in),
    .ctrl_tok   (ctrl_tok),
    .phase_count(phase_count),
    .count_valid(count_valid),
    .loop_fault (loop_fault)
  );

  assign tok_chain[0] = ctrl_tok;

  generate
    for (genvar i = 0; i < N_PHASES; i++) begin : g_stage
      phase_chain_stage #(
        .CLOCK_TIMED(SINGLE)
      ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .tok_in   (tok_chain[i]),
        .run      (count_valid),
        .iso      (phase_iso[i]),
        .tok_out  (tok_chain[i+1]),
        .pwm_start(pwm_start[i])
      );
    end
  endgenerate

  assign ring_out = tok_chain[N_PHASES];

endmodule

// File: rtl/phase_chain_chk.sv
module phase_chain_chk #(
  parameter int N_PHASES = 4,
  parameter int MAX_WAIT = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [N_PHASES-1:0]           phase_iso,
  input logic [N_PHASES-1:0]           pwm_start,
  input logic [$clog2(MAX_WAIT+1)-1:0] phase_count,
  input logic                          count_valid,
  input logic                          loop_fault,
  input logic                          ctrl_tok
);

  localparam int CNT_W = $clog2(MAX_WAIT + 1);

  logic [CNT_W+1:0] since_rst;
  logic [CNT_W:0]   inj_gap;
  logic             inj_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rst <= '0;
      inj_gap   <= '0;
      inj_seen  <= 1'b0;
    end else begin
      if (!(&since_rst)) since_rst <= since_rst + 1'b1;
      if (ctrl_tok)            inj_gap <= {{CNT_W{1'b0}}, 1'b1};
      else if (!(&inj_gap))    inj_gap <= inj_gap + 1'b1;
      if (ctrl_tok && count_valid) inj_seen <= 1'b1;
    end
  end

  AST_DISC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_tok && !count_valid) |-> since_rst == (CNT_W+2)'(1)); // R2

  AST_VALID_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(count_valid) |-> since_rst == ({2'b00, phase_count} + (CNT_W+2)'(2))); // R3

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    count_valid |=> (count_valid && $stable(phase_count))); // R3

  AST_FAULT_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_fault) |-> (since_rst == (CNT_W+2)'(MAX_WAIT + 2) ||
                           since_rst == (CNT_W+2)'(2))); // R4

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    loop_fault |=> (loop_fault && !count_valid)); // R4

  AST_RUN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (count_valid && ctrl_tok && inj_seen) |-> inj_gap == {1'b0, phase_count}); // R6

  AST_NO_PWM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|pwm_start) |-> count_valid); // R7

  AST_ISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_start & phase_iso) == '0); // R8

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (count_valid && int'(phase_count) >= N_PHASES) |-> $onehot0(pwm_start)); // R9

endmodule

bind phase_chain_seq phase_chain_chk #(
  .N_PHASES(N_PHASES),
  .MAX_WAIT(MAX_WAIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase_iso  (phase_iso),
  .pwm_start  (pwm_start),
  .phase_count(phase_count),
  .count_valid(count_valid),
  .loop_fault (loop_fault),
  .ctrl_tok   (ctrl_tok)
);

// File: tb/phase_chain_seq_bench.sv
module phase_chain_seq_bench;

  localparam int N    = 4;
  localparam int MAXW = 16;
  localparam int CW   = $clog2(MAXW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  iso = '0;
  logic          ring_in;
  logic          ring_out;
  logic [N-1:0]  pwm;
  logic [CW-1:0] pcount;
  logic          valid;
  logic          fault;

  logic          s_ring;
  logic [0:0]    s_pwm;
  logic [CW-1:0] s_pcount;
  logic          s_valid;
  logic          s_fault;

  int mode = 0;  // 0 delayed return, 1 open loop, 2 stuck high
  int dsel = 0;
  logic [31:0] dly = '0;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  always @(posedge clk) dly <= {dly[30:0], ring_out};

  always_comb begin
    if (mode == 1)      ring_in = 1'b0;
    else if (mode == 2) ring_in = 1'b1;
    else if (dsel == 0) ring_in = ring_out;
    else                ring_in = dly[(dsel > 0) ? dsel - 1 : 0];
  end

  phase_chain_seq #(.N_PHASES(N), .MAX_WAIT(MAXW)) u_phase_chain_seq (
    .clk(clk), .rst_n(rst_n), .phase_iso(iso), .ring_in(ring_in),
    .ring_out(ring_out), .pwm_start(pwm), .phase_count(pcount),
    .count_valid(valid), .loop_fault(fault)
  );

  phase_chain_seq #(.N_PHASES(1), .MAX_WAIT(MAXW)) u_phase_chain_seq1 (
    .clk(clk), .rst_n(rst_n), .phase_iso(1'b0), .ring_in(s_ring),
    .ring_out(s_ring), .pwm_start(s_pwm), .phase_count(s_pcount),
    .count_valid(s_valid), .loop_fault(s_fault)
  );

  // Expected model, edge k counted from the first edge with rst_n high.
  function automatic bit e_inj(int k, int pc, int md);
    if (k == 0) return 1'b1;
    if (md != 0 || pc > MAXW || k < pc + 1) return 1'b0;
    return ((k - pc - 1) % pc) == 0;
  endfunction

  function automatic bit e_valid(int k, int pc, int md);
    return (md == 0) && (pc <= MAXW) && (k >= pc + 1);
  endfunction

  function automatic bit e_fault(int k, int pc, int md);
    if (md == 2) return k >= 1;
    if (md == 1 || pc > MAXW) return k >= MAXW + 1;
    return 1'b0;
  endfunction

  function automatic bit e_tok(int i, int k, int pc, int md);
    if (k - 1 - i < 0) return 1'b0;
    return e_inj(k - 1 - i, pc, md);
  endfunction

  task automatic chk(string req, int k, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s k=%0d actual=%0d expected=%0d", req, k, act, exp);
    end
  endtask

  task automatic run_scn(int md, int d, logic [N-1:0] iso_v, int ncyc);
    int pc;
    @(negedge clk);
    rst_n = 1'b0;
    mode  = md;
    dsel  = d;
    iso   = iso_v;
    pc    = N + d;
    repeat (20) @(negedge clk);
    chk("R1 pwm_start", -1, int'(pwm), 0);
    chk("R1 ring_out", -1, int'(ring_out), 0);
    chk("R1 phase_count", -1, int'(pcount), 0);
    chk("R1 count_valid", -1, int'(valid), 0);
    chk("R1 loop_fault", -1, int'(fault), 0);
    chk("R1 single pwm", -1, int'(s_pwm), 0);
    rst_n = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      bit ev;
      @(negedge clk);
      ev = e_valid(k, pc, md);
      chk("R2 ring_out", k, int'(ring_out), int'(e_tok(N - 1, k, pc, md)));
      chk("R3 count_valid", k, int'(valid), int'(ev));
      if (ev) chk("R3 phase_count", k, int'(pcount), pc);
      chk((md == 2) ? "R5 loop_fault" : "R4 loop_fault", k, int'(fault),
          int'(e_fault(k, pc, md)));
      for (int i = 0; i < N; i++) begin
        bit ep;
        ep = e_tok(i, k, pc, md) && ev && !iso_v[i];
        if (iso_v[i])  chk("R8 pwm_start", k, int'(pwm[i]), int'(ep));
        else if (!ev)  chk("R7 pwm_start", k, int'(pwm[i]), int'(ep));
        else           chk("R6 pwm_start", k, int'(pwm[i]), int'(ep));
      end
      chk("R9 one strobe", k, int'($countones(pwm) <= 1), 1);
      chk("R10 single pwm", k, int'(s_pwm[0]), int'(k >= 2));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_scn(0, 0, 4'b0000, 40);               // R2 R3 R6 R9 nominal ring
    run_scn(0, MAXW - N, 4'b0000, 60);        // R3 longest accepted count
    run_scn(0, MAXW - N + 1, 4'b0000, 40);    // R4 one past the limit
    run_scn(1, 0, 4'b0000, 40);               // R4 open loop
    run_scn(2, 0, 4'b0000, 20);               // R5 stuck-high return
    run_scn(0, 0, 4'b0101, 40);               // R8 isolated stages
    run_scn(0, 3, 4'b1000, 50);               // R8 last stage isolated
    for (int s = 0; s < 8; s++) begin
      int d;
      d = int'($urandom % (MAXW - N + 3));
      run_scn(0, d, N'($urandom % 16), 60);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule